// File: doc/BRIEF.md
# Circular Push/Pull Queue Engine

This block keeps a circular queue of 64-bit (8-byte) entries in an internal register array. A producer places entries through a write port and a consumer takes them out, oldest first, through a read port. Used as a push queue, the check of interest is a write into a full queue. Used as a pull queue, it is a read from an empty queue. Each check has its own enable input, and each flags its event in a sticky error bit.

A 32-bit control word sets how deep the queue is, which condition drives the interrupt, and whether the queue runs at all. The stored length plus one gives the number of entries. The head and tail indices wrap to zero after they pass the stored length, so the depth can be changed at run time without moving storage. The interrupt is a level that follows one of four conditions: full, not full, empty or not empty. The block also holds two separate 8-byte-aligned base addresses, one for push use and one for pull use. These are held for the surrounding logic and have no effect on the queue itself.

Top module: `circq_engine`

## Requirements
- R1: After reset, the control word reads 0, both base addresses read 0, both error flags are 0, the fill level is 0, empty is 1, full is 0 and the interrupt is 0.
- R2: A control write stores bit 31 (enable), bits 10:6 (length L) and bits 5:4 (interrupt select), and reads them back at the same positions. All other bits read as 0.
- R3: The queue holds L+1 entries. `full` is 1 exactly when the fill level equals L+1, `empty` is 1 exactly when it is 0, and the two are never 1 together.
- R4: Entries leave in the order they entered, including after the head and tail indices wrap past L.
- R5: A write to a full, enabled queue is dropped, even if a read is accepted in the same cycle. If `ovf_chk_en` is 1, it also sets `ovf_err`, which then stays 1 until reset.
- R6: A read from an empty, enabled queue returns 0 and leaves the fill level unchanged. If `unf_chk_en` is 1, it also sets `unf_err`, which then stays 1 until reset. `rd_data` is 0 in any cycle without an accepted read.
- R7: `irq` equals the enable bit ANDed with the selected condition: select 00 = full, 01 = not full, 10 = empty, 11 = not empty.
- R8: A control write that changes L or clears the enable bit empties the queue. A control write that changes only the select leaves the contents alone. In a cycle with a control write, data reads and writes are ignored.
- R9: While the enable bit is 0, writes and reads have no effect: the fill level stays, `rd_data` is 0 and no error flag is set.
- R10: `base_we` with `base_sel`=0 loads the push base, and with `base_sel`=1 loads the pull base. The other base is left unchanged. Bits 2:0 of each base read as 0.
- R11: A write to a full queue while `ovf_chk_en` is 0 is dropped and does not set `ovf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word to write |
| ctl_rdata | output | 32 | Stored control word |
| base_we | input | 1 | Base address write strobe |
| base_sel | input | 1 | 0 selects the push base, 1 selects the pull base |
| base_wdata | input | BASE_W | Base address to write |
| push_base | output | BASE_W | Push queue base address, 8-byte aligned |
| pull_base | output | BASE_W | Pull queue base address, 8-byte aligned |
| ovf_chk_en | input | 1 | Enables the overflow flag |
| unf_chk_en | input | 1 | Enables the underflow flag |
| wr_en | input | 1 | Write one entry |
| wr_data | input | DATA_W | Entry to write |
| rd_en | input | 1 | Read one entry |
| rd_data | output | DATA_W | Entry read this cycle, or 0 |
| full | output | 1 | Queue holds L+1 entries |
| empty | output | 1 | Queue holds no entry |
| fill | output | 6 | Number of entries held |
| irq | output | 1 | Level interrupt |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
Some properties are checked on every cycle: full and empty are never 1 together, the fill level is held over a write to a full queue, a read from an empty queue returns zero, the interrupt is silent while the queue is disabled, a control write that clears the enable leaves the queue empty, and the error flags stay set once set. Other behaviour only the directed scenarios can show. These are the exact entry order across index wrap, the depth that follows each programmed length, each of the four interrupt conditions, a select-only control write keeping the contents, and the separation of the two base addresses with their alignment.

// File: rtl/qe_pkg.sv
package qe_pkg;

    localparam int LEN_W   = 5;
    localparam int DEPTH   = 1 << LEN_W;
    localparam int CNT_W   = LEN_W + 1;
    localparam int ALIGN   = 3;

    localparam int EN_BIT  = 31;
    localparam int LEN_LO  = 6;
    localparam int LEN_HI  = LEN_LO + LEN_W - 1;
    localparam int SEL_LO  = 4;
    localparam int SEL_HI  = 5;

    typedef enum logic [1:0] {
        IRQ_FULL      = 2'b00,
        IRQ_NOT_FULL  = 2'b01,
        IRQ_EMPTY     = 2'b10,
        IRQ_NOT_EMPTY = 2'b11
    } irq_sel_e;

    typedef struct packed {
        logic             en;
        logic [LEN_W-1:0] len;
        irq_sel_e         sel;
    } qe_ctl_t;

    function automatic qe_ctl_t unpack_ctl(input logic [31:0] w);
        qe_ctl_t c;
        c.en  = w[EN_BIT];
        c.len = w[LEN_HI:LEN_LO];
        c.sel = irq_sel_e'(w[SEL_HI:SEL_LO]);
        return c;
    endfunction

    function automatic logic [31:0] pack_ctl(input qe_ctl_t c);
        logic [31:0] w;
        w                = '0;
        w[EN_BIT]        = c.en;
        w[LEN_HI:LEN_LO] = c.len;
        w[SEL_HI:SEL_LO] = c.sel;
        return w;
    endfunction

    function automatic logic [LEN_W-1:0] wrap_inc(input logic [LEN_W-1:0] p,
                                                  input logic [LEN_W-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/qe_cfg.sv
module qe_cfg #(
    parameter int BASE_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctl_we,
    input  logic [31:0]           ctl_wdata,
    input  logic                  base_we,
    input  logic                  base_sel,
    input  logic [BASE_W-1:0]     base_wdata,
    output qe_pkg::qe_ctl_t       ctl,
    output logic                  clr_ptrs,
    output logic [BASE_W-1:0]     push_base,
    output logic [BASE_W-1:0]     pull_base
);
    import qe_pkg::*;

    localparam int NQ = 2;

    qe_ctl_t ctl_q;
    qe_ctl_t ctl_nxt;
    logic    unused_lowbits;

    assign ctl_nxt        = unpack_ctl(ctl_wdata);
    assign unused_lowbits = ^{ctl_wdata[EN_BIT-1:LEN_HI+1], ctl_wdata[SEL_LO-1:0],
                              base_wdata[ALIGN-1:0]};

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_nxt;
    end

    assign ctl      = ctl_q;
    assign clr_ptrs = ctl_we && (!ctl_nxt.en || (ctl_nxt.len != ctl_q.len));

    logic [BASE_W-1:ALIGN] base_q [NQ];

    for (genvar q = 0; q < NQ; q++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst)
                base_q[q] <= '0;
            else if (base_we && (base_sel == q[0]))
                base_q[q] <= base_wdata[BASE_W-1:ALIGN];
        end
    end

    assign push_base = {base_q[0], {ALIGN{1'b0}}};
    assign pull_base = {base_q[1], {ALIGN{1'b0}}};

endmodule

// File: rtl/qe_ptrs.sv
module qe_ptrs (
    input  logic                      clk,
    input  logic                      rst,
    input  qe_pkg::qe_ctl_t           ctl,
    input  logic                      clr_ptrs,
    input  logic                      blk,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic                      ovf_chk_en,
    input  logic                      unf_chk_en,
    output logic [qe_pkg::LEN_W-1:0]  head,
    output logic [qe_pkg::LEN_W-1:0]  tail,
    output logic [qe_pkg::CNT_W-1:0]  count,
    output logic                      push_ok,
    output logic                      pop_ok,
    output logic                      full,
    output logic                      empty,
    output logic                      ovf_err,
    output logic                      unf_err
);
    import qe_pkg::*;

    logic [CNT_W-1:0] depth;
    logic             live;
    logic             ovf_evt;
    logic             unf_evt;

    assign depth   = {1'b0, ctl.len} + 1'b1;
    assign full    = (count == depth);
    assign empty   = (count == '0);
    assign live    = ctl.en && !blk;
    assign push_ok = live && wr_en && !full;
    assign pop_ok  = live && rd_en && !empty;
    assign ovf_evt = live && wr_en && full  && ovf_chk_en;
    assign unf_evt = live && rd_en && empty && unf_chk_en;

    always_ff @(posedge clk) begin
        if (rst || clr_ptrs) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push_ok) tail <= wrap_inc(tail, ctl.len);
            if (pop_ok)  head <= wrap_inc(head, ctl.len);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            if (ovf_evt) ovf_err <= 1'b1;
            if (unf_evt) unf_err <= 1'b1;
        end
    end

endmodule

// File: rtl/qe_store.sv
module qe_store #(
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [qe_pkg::LEN_W-1:0]  waddr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [qe_pkg::LEN_W-1:0]  raddr,
    output logic [DATA_W-1:0]         rdata
);
    import qe_pkg::*;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/circq_engine.sv
module circq_engine #(
    parameter int DATA_W = 64,
    parameter int BASE_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ctl_we,
    input  logic [31:0]              ctl_wdata,
    output logic [31:0]              ctl_rdata,
    input  logic                     base_we,
    input  logic                     base_sel,
    input  logic [BASE_W-1:0]        base_wdata,
    output logic [BASE_W-1:0]        push_base,
    output logic [BASE_W-1:0]        pull_base,
    input  logic                     ovf_chk_en,
    input  logic                     unf_chk_en,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     full,
    output logic                     empty,
    output logic [qe_pkg::CNT_W-1:0] fill,
    output logic                     irq,
    output logic                     ovf_err,
    output logic                     unf_err
);
    import qe_pkg::*;

    qe_ctl_t           ctl;
    logic              clr_ptrs;
    logic [LEN_W-1:0]  head;
    logic [LEN_W-1:0]  tail;
    logic              push_ok;
    logic              pop_ok;
    logic [DATA_W-1:0] head_data;
    logic              cond;

    qe_cfg #(.BASE_W(BASE_W)) i_cfg (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .base_we    (base_we),
        .base_sel   (base_sel),
        .base_wdata (base_wdata),
        .ctl        (ctl),
        .clr_ptrs   (clr_ptrs),
        .push_base  (push_base),
        .pull_base  (pull_base)
    );

    qe_ptrs i_ptrs (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .clr_ptrs   (clr_ptrs),
        .blk        (ctl_we),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .ovf_chk_en (ovf_chk_en),
        .unf_chk_en (unf_chk_en),
        .head       (head),
        .tail       (tail),
        .count      (fill),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .full       (full),
        .empty      (empty),
        .ovf_err    (ovf_err),
        .unf_err    (unf_err)
    );

    qe_store #(.DATA_W(DATA_W)) i_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (tail),
        .wdata (wr_data),
        .raddr (head),
        .rdata (head_data)
    );

    always_comb begin
        case (ctl.sel)
            IRQ_FULL:      cond = full;
            IRQ_NOT_FULL:  cond = !full;
            IRQ_EMPTY:     cond = empty;
            default:       cond = !empty;
        endcase
    end

    assign irq       = ctl.en && cond;
    assign rd_data   = pop_ok ? head_data : '0;
    assign ctl_rdata = pack_ctl(ctl);

endmodule

// File: rtl/circq_engine_chk.sv
module circq_engine_chk #(
    parameter int DATA_W = 64
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ctl_we,
    input logic [31:0]              ctl_wdata,
    input logic [31:0]              ctl_rdata,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     full,
    input logic                     empty,
    input logic [qe_pkg::CNT_W-1:0] fill,
    input logic                     irq,
    input logic                     ovf_err,
    input logic                     unf_err
);
    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[31] && full && wr_en && !rd_en && !ctl_we) |=> (fill == $past(fill)));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    // R6
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unf_err |=> unf_err);

    // R6
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en) |-> (rd_data == '0));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[31] |-> !irq);

    // R8
    disable_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !ctl_wdata[31]) |=> empty);

endmodule

bind circq_engine circq_engine_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .full      (full),
    .empty     (empty),
    .fill      (fill),
    .irq       (irq),
    .ovf_err   (ovf_err),
    .unf_err   (unf_err)
);

// File: tb/test_circq_engine.sv
module test_circq_engine;

    localparam int DATA_W = 64;
    localparam int BASE_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_we = 1'b0;
    logic [31:0]       ctl_wdata = '0;
    logic [31:0]       ctl_rdata;
    logic              base_we = 1'b0;
    logic              base_sel = 1'b0;
    logic [BASE_W-1:0] base_wdata = '0;
    logic [BASE_W-1:0] push_base;
    logic [BASE_W-1:0] pull_base;
    logic              ovf_chk_en = 1'b0;
    logic              unf_chk_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              full;
    logic              empty;
    logic [5:0]        fill;
    logic              irq;
    logic              ovf_err;
    logic              unf_err;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    circq_engine #(.DATA_W(DATA_W), .BASE_W(BASE_W)) i_circq_engine (
        .clk(clk), .rst(rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
        .push_base(push_base), .pull_base(pull_base),
        .ovf_chk_en(ovf_chk_en), .unf_chk_en(unf_chk_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .empty(empty), .fill(fill), .irq(irq),
        .ovf_err(ovf_err), .unf_err(unf_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input logic en, input logic [4:0] len,
                                           input logic [1:0] sel);
        return {en, 20'b0, len, sel, 4'b0};
    endfunction

    task automatic ctl_wr(input logic [31:0] w);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic push(input logic [63:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop(output logic [63:0] d);
        @(negedge clk); rd_en = 1'b1; #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 ctl", ctl_rdata, 0);
        check("R1 push_base", push_base, 0);
        check("R1 pull_base", pull_base, 0);
        check("R1 errs", {ovf_err, unf_err}, 0);
        check("R1 fill", fill, 0);
        check("R1 empty/full/irq", {empty, full, irq}, 3'b100);
    endtask

    task automatic t_disabled;
        logic [63:0] d;
        ovf_chk_en = 1'b1; unf_chk_en = 1'b1;
        ctl_wr(mk_ctl(1'b0, 5'd3, 2'b10));
        check("R7 irq gated by enable", irq, 0);
        push(64'hAAAA);
        check("R9 write ignored", fill, 0);
        pop(d);
        check("R9 read data zero", d, 0);
        check("R9 no error flags", {ovf_err, unf_err}, 0);
        ovf_chk_en = 1'b0; unf_chk_en = 1'b0;
    endtask

    task automatic t_readback;
        ctl_wr(32'hFFFF_FFFF);
        check("R2 field readback", ctl_rdata, 32'h8000_07F0);
        ctl_wr(mk_ctl(1'b1, 5'd3, 2'b00));
        check("R2 programmed word", ctl_rdata, 32'h8000_00C0);
    endtask

    task automatic t_fill;
        check("R7 full select, empty queue", irq, 0);
        for (int i = 0; i < 4; i++) push(64'h1000 + 64'(i));
        check("R3 fill L+1", fill, 4);
        check("R3 full flag", {full, empty}, 2'b10);
        check("R7 full select, full queue", irq, 1);
    endtask

    task automatic t_overflow;
        push(64'hDEAD);
        check("R11 dropped write keeps fill", fill, 4);
        check("R11 no flag when check off", ovf_err, 0);
        ovf_chk_en = 1'b1;
        push(64'hBEEF);
        check("R5 overflow flag", ovf_err, 1);
        check("R5 fill unchanged", fill, 4);
        ovf_chk_en = 1'b0;
    endtask

    task automatic t_wrap;
        logic [63:0] d;
        pop(d); check("R4 order 0", d, 64'h1000);
        pop(d); check("R4 order 1", d, 64'h1001);
        push(64'h1004);
        push(64'h1005);
        for (int i = 2; i < 6; i++) begin
            pop(d);
            check("R4 order after wrap", d, 64'h1000 + 64'(i));
        end
        check("R3 empty after drain", {full, empty}, 2'b01);
        check("R5 overflow flag sticky", ovf_err, 1);
    endtask

    task automatic t_underflow;
        logic [63:0] d;
        unf_chk_en = 1'b1;
        pop(d);
        check("R6 underflow read zero", d, 0);
        check("R6 underflow flag", unf_err, 1);
        check("R6 fill unchanged", fill, 0);
        push(64'h77);
        pop(d);
        check("R6 pointers kept after underflow", d, 64'h77);
        unf_chk_en = 1'b0;
    endtask

    task automatic t_irq_sel;
        push(64'h55);
        ctl_wr(mk_ctl(1'b1, 5'd3, 2'b11));
        check("R8 select-only write keeps contents", fill, 1);
        check("R7 not empty select", irq, 1);
        ctl_wr(mk_ctl(1'b1, 5'd3, 2'b10));
        check("R7 empty select", irq, 0);
        ctl_wr(mk_ctl(1'b1, 5'd3, 2'b01));
        check("R7 not full select", irq, 1);
    endtask

    task automatic t_len_change;
        ctl_wr(mk_ctl(1'b1, 5'd0, 2'b00));
        check("R8 length change empties", fill, 0);
        push(64'h99);
        check("R3 depth one full", {full, fill}, {1'b1, 6'd1});
        ctl_wr(mk_ctl(1'b0, 5'd0, 2'b00));
        check("R8 disable empties", {empty, irq}, 2'b10);
    endtask

    task automatic t_base;
        @(negedge clk); base_we = 1'b1; base_sel = 1'b0; base_wdata = 32'h1234_5677;
        @(negedge clk); base_sel = 1'b1; base_wdata = 32'hFFFF_FFFF;
        @(negedge clk); base_we = 1'b0;
        check("R10 push base aligned", push_base, 32'h1234_5670);
        check("R10 pull base aligned", pull_base, 32'hFFFF_FFF8);
        @(negedge clk); base_we = 1'b1; base_sel = 1'b0; base_wdata = 32'h0000_0040;
        @(negedge clk); base_we = 1'b0;
        check("R10 pull base untouched", pull_base, 32'hFFFF_FFF8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_readback();
        t_fill();
        t_overflow();
        t_wrap();
        t_underflow();
        t_irq_sel();
        t_len_change();
        t_base();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule